// File: doc/BRIEF.md
# Coin-Operated Vending Controller

This block is the control core of a machine selling one item for 35 cents. Each clock cycle a 2-bit coin code arrives: no coin, a nickel, a dime or a quarter. The controller keeps the credit inserted so far as part of its state, in 5-cent steps. When a coin brings the credit to 35 cents or more, it raises `dispense` for one cycle. Any overpayment is then handed back as a run of single-coin pulses on `refund_coin`, which uses the same 2-bit code as `coin`.

Outputs come only from the registered state. The state is kept as a phase (collecting, dispensing, refunding) plus a count of 5-cent units. That count is the credit while collecting and the amount still owed while refunding. The highest credit the machine can reach is 55 cents: 30 cents followed by a quarter. The largest refund is therefore 20 cents, paid as two dimes.

The coin pins carry no handshake. A coin lasts one cycle and is either counted or ignored, so a valid/ready pair would have nothing to hold back. An active-high asynchronous reset returns the machine to idle.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high, the machine is idle with zero credit and `dispense`=0, `refund_coin`=00. This holds at once, without waiting for a clock edge, and credit held before the reset is lost.
- R2: Coin codes are 00 none, 01 nickel (5), 10 dime (10), 11 quarter (25). While the credit is below 35 cents, each coin adds its value at the rising edge and both outputs stay 0.
- R3: In the cycle after the edge at which a coin makes the credit at least 35 cents, `dispense` is 1 for exactly one cycle. It pulses once per purchase.
- R4: With exactly 35 cents there is no refund, and the machine is idle in the cycle after the `dispense` pulse.
- R5: An excess is refunded largest coin first, on consecutive cycles starting the cycle after `dispense`. 20 cents gives 10,10; 15 gives 10,01; 10 gives 10; 5 gives 01.
- R6: `refund_coin` is never 11, and it is never non-zero in the same cycle as `dispense`.
- R7: A coin presented in a cycle where `dispense` is 1 or `refund_coin` is non-zero is ignored and adds no credit.
- R8: The machine is idle with zero credit in the cycle after the last refund pulse.
- R9: A cycle with coin code 00 leaves the credit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| coin | input | 2 | Coin entered this cycle (00 none, 01 nickel, 10 dime, 11 quarter) |
| dispense | output | 1 | One-cycle pulse that releases the item |
| refund_coin | output | 2 | Refund coin this cycle, same code as `coin` |

## Verification
Every result is one register stage behind its cause. A coin sampled at edge k shows up in the outputs after edge k. `dispense` appears in the cycle after the completing coin, and the refund pulses follow in cycles 2, 3 and so on after it. The bench drives and samples on the falling edge. For each purchase it compares a fixed six-cycle window after the last coin against the cycle-by-cycle expected pattern, so a pulse that is one cycle early or late counts as a failure.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,
    PH_VEND    = 2'd1,
    PH_REFUND  = 2'd2
  } phase_e;

  localparam logic [1:0] CODE_NONE    = 2'b00;
  localparam logic [1:0] CODE_NICKEL  = 2'b01;
  localparam logic [1:0] CODE_DIME    = 2'b10;
  localparam logic [1:0] CODE_QUARTER = 2'b11;

  // coin worth in 5-cent units
  localparam int NICKEL_UNITS  = 1;
  localparam int DIME_UNITS    = 2;
  localparam int QUARTER_UNITS = 5;
endpackage

// File: rtl/vend_tally.sv
module vend_tally
  import vend_pkg::*;
#(
  parameter int PRICE_UNITS = 7,
  parameter int UNIT_W      = 4
) (
  input  phase_e              phase,
  input  logic [UNIT_W-1:0]   units,
  input  logic [1:0]          coin,
  output phase_e              nxt_phase,
  output logic [UNIT_W-1:0]   nxt_units
);
  localparam logic [UNIT_W-1:0] PRICE_U = UNIT_W'(PRICE_UNITS);
  localparam logic [UNIT_W-1:0] ONE_U   = UNIT_W'(NICKEL_UNITS);
  localparam logic [UNIT_W-1:0] TWO_U   = UNIT_W'(DIME_UNITS);
  localparam logic [UNIT_W-1:0] FIVE_U  = UNIT_W'(QUARTER_UNITS);

  logic [UNIT_W-1:0] coin_val;
  logic [UNIT_W-1:0] sum;
  logic [UNIT_W-1:0] step;
  logic [UNIT_W-1:0] rest;

  always_comb begin
    case (coin)
      CODE_NICKEL:  coin_val = ONE_U;
      CODE_DIME:    coin_val = TWO_U;
      CODE_QUARTER: coin_val = FIVE_U;
      default:      coin_val = '0;
    endcase
  end

  assign sum  = units + coin_val;
  assign step = (units >= TWO_U) ? TWO_U : ONE_U;
  assign rest = units - step;

  always_comb begin
    nxt_phase = PH_COLLECT;
    nxt_units = '0;
    case (phase)
      PH_COLLECT: begin
        if (sum >= PRICE_U) begin
          nxt_phase = PH_VEND;
          nxt_units = sum - PRICE_U;
        end else begin
          nxt_units = sum;
        end
      end
      PH_VEND: begin
        if (units != '0) begin
          nxt_phase = PH_REFUND;
          nxt_units = units;
        end
      end
      PH_REFUND: begin
        if (rest != '0) begin
          nxt_phase = PH_REFUND;
          nxt_units = rest;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vend_decode.sv
module vend_decode
  import vend_pkg::*;
#(
  parameter int UNIT_W = 4
) (
  input  phase_e            phase,
  input  logic [UNIT_W-1:0] units,
  output logic              dispense,
  output logic [1:0]        refund_coin
);
  localparam logic [UNIT_W-1:0] TWO_U = UNIT_W'(DIME_UNITS);

  always_comb begin
    dispense    = 1'b0;
    refund_coin = CODE_NONE;
    case (phase)
      PH_VEND:   dispense = 1'b1;
      PH_REFUND: refund_coin = (units >= TWO_U) ? CODE_DIME : CODE_NICKEL;
      default: ;
    endcase
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int PRICE_UNITS = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] coin,
  output logic       dispense,
  output logic [1:0] refund_coin
);
  localparam int UNIT_W = $clog2(PRICE_UNITS + QUARTER_UNITS);

  phase_e            phase_q, phase_d;
  logic [UNIT_W-1:0] units_q, units_d;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase_q <= PH_COLLECT;
      units_q <= '0;
    end else begin
      phase_q <= phase_d;
      units_q <= units_d;
    end
  end

  vend_tally #(.PRICE_UNITS(PRICE_UNITS), .UNIT_W(UNIT_W)) u_tally (
    .phase     (phase_q),
    .units     (units_q),
    .coin      (coin),
    .nxt_phase (phase_d),
    .nxt_units (units_d)
  );

  vend_decode #(.UNIT_W(UNIT_W)) u_decode (
    .phase       (phase_q),
    .units       (units_q),
    .dispense    (dispense),
    .refund_coin (refund_coin)
  );
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] coin,
  input logic       dispense,
  input logic [1:0] refund_coin
);
  // R6
  no_quarter_refund_chk: assert property (@(posedge clk) disable iff (rst)
    refund_coin != 2'b11);

  // R6
  no_vend_with_refund_chk: assert property (@(posedge clk) disable iff (rst)
    !(dispense && refund_coin != 2'b00));

  // R3
  single_vend_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dispense |=> !dispense);

  // R3
  vend_needs_coin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dispense) |-> $past(coin) != 2'b00);

  // R5
  refund_follows_vend_chk: assert property (@(posedge clk) disable iff (rst)
    (refund_coin != 2'b00) |-> ($past(dispense) || $past(refund_coin) != 2'b00));

  // R7
  vend_not_after_vend_chk: assert property (@(posedge clk) disable iff (rst)
    (refund_coin != 2'b00) |=> !dispense);
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .coin        (coin),
  .dispense    (dispense),
  .refund_coin (refund_coin)
);

// File: tb/vend_ctrl_tb.sv
module vend_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] coin = 2'b00;
  logic       dispense;
  logic [1:0] refund_coin;

  int tests_run = 0;
  int tests_failed = 0;
  logic [1:0] seq_code [0:7];
  int seq_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  vend_ctrl u_dut (
    .clk         (clk),
    .rst         (rst),
    .coin        (coin),
    .dispense    (dispense),
    .refund_coin (refund_coin)
  );

  function automatic int units_of(input logic [1:0] c);
    case (c)
      2'b01: return 1;
      2'b10: return 2;
      2'b11: return 5;
      default: return 0;
    endcase
  endfunction

  // Plays seq_code, with gap idle cycles after each coin, then checks a window.
  task automatic run_seq(input int gap, input bit ign, input string tag);
    int total;
    int excess;
    bit acc_bad;
    logic       exp_d [0:WIN-1];
    logic [1:0] exp_c [0:WIN-1];
    logic       got_d [0:WIN-1];
    logic [1:0] got_c [0:WIN-1];
    bit win_bad;
    total = 0;
    acc_bad = 0;
    for (int i = 0; i < seq_len; i++) begin
      @(negedge clk);
      if (dispense !== 1'b0 || refund_coin !== 2'b00) acc_bad = 1;
      coin = seq_code[i];
      total += units_of(seq_code[i]);
      if (i != seq_len - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (dispense !== 1'b0 || refund_coin !== 2'b00) acc_bad = 1;
          coin = 2'b00;
        end
      end
    end
    tests_run++;
    if (acc_bad) begin
      tests_failed++;
      $display("FAIL R2/R9 %s: output active while collecting, expected dispense=0 refund=00", tag);
    end
    excess = total - 7;
    for (int k = 0; k < WIN; k++) begin
      exp_d[k] = (k == 0);
      exp_c[k] = 2'b00;
    end
    for (int k = 1; excess > 0; k++) begin
      if (excess >= 2) begin exp_c[k] = 2'b10; excess -= 2; end
      else begin exp_c[k] = 2'b01; excess -= 1; end
    end
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      got_d[k] = dispense;
      got_c[k] = refund_coin;
      coin = (ign && (exp_d[k] || exp_c[k] != 2'b00)) ? 2'b11 : 2'b00;
    end
    coin = 2'b00;
    tests_run++;
    win_bad = 0;
    for (int k = 0; k < WIN; k++)
      if (got_d[k] !== exp_d[k] || got_c[k] !== exp_c[k]) win_bad = 1;
    if (win_bad) begin
      tests_failed++;
      for (int k = 0; k < WIN; k++)
        $display("FAIL R3/R4/R5/R6/R8 %s cycle %0d: got dispense=%b refund=%b expected dispense=%b refund=%b",
                 tag, k, got_d[k], got_c[k], exp_d[k], exp_c[k]);
    end
  endtask

  // R1: reset state, and reset during collection clears credit
  task automatic test_reset();
    @(negedge clk);
    tests_run++;
    if (dispense !== 1'b0 || refund_coin !== 2'b00) begin
      tests_failed++;
      $display("FAIL R1 reset state: got dispense=%b refund=%b expected 0/00", dispense, refund_coin);
    end
    rst = 1'b0;
    @(negedge clk);
    coin = 2'b11;
    @(posedge clk);
    #1 coin = 2'b00;
    rst = 1'b1;
    #1;
    tests_run++;
    if (dispense !== 1'b0 || refund_coin !== 2'b00) begin
      tests_failed++;
      $display("FAIL R1 async reset: got dispense=%b refund=%b expected 0/00", dispense, refund_coin);
    end
    #1 rst = 1'b0;
    // credit must restart at zero: dime then quarter is an exact sale
    seq_code[0] = 2'b10; seq_code[1] = 2'b11; seq_len = 2;
    run_seq(0, 0, "R1 credit cleared");
  endtask

  // R2..R6, R8: every coin order that first reaches 35..55 cents
  task automatic test_all_sequences();
    int p;
    int digits [0:7];
    int pre;
    bit ok;
    for (int len = 2; len <= 7; len++) begin
      p = 1;
      for (int j = 0; j < len; j++) p *= 3;
      for (int n = 0; n < p; n++) begin
        int v;
        v = n;
        for (int j = 0; j < len; j++) begin
          digits[j] = v % 3;
          v = v / 3;
        end
        pre = 0;
        for (int j = 0; j < len; j++) seq_code[j] = 2'(digits[j] + 1);
        for (int j = 0; j < len - 1; j++) pre += units_of(seq_code[j]);
        ok = (pre < 7) && (pre + units_of(seq_code[len-1]) >= 7);
        if (ok) begin
          seq_len = len;
          run_seq(0, 0, "sequence");
        end
      end
    end
  endtask

  // R9: idle cycles between coins keep credit
  task automatic test_gaps();
    seq_code[0] = 2'b11; seq_code[1] = 2'b01; seq_code[2] = 2'b11; seq_len = 3;
    run_seq(3, 0, "R9 gaps 55c");
    seq_code[0] = 2'b10; seq_code[1] = 2'b10; seq_code[2] = 2'b10; seq_code[3] = 2'b01; seq_len = 4;
    run_seq(2, 0, "R9 gaps 35c");
  endtask

  // R7: quarters during dispense/refund are ignored
  task automatic test_ignore();
    seq_code[0] = 2'b11; seq_code[1] = 2'b01; seq_code[2] = 2'b11; seq_len = 3;
    run_seq(0, 1, "R7 ignore 20c refund");
    seq_code[0] = 2'b11; seq_code[1] = 2'b10; seq_len = 2;
    run_seq(0, 1, "R7 ignore exact");
    // next sale starts from zero credit if nothing was counted
    seq_code[0] = 2'b11; seq_code[1] = 2'b10; seq_len = 2;
    run_seq(0, 0, "R7 R8 following sale");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    test_reset();
    test_gaps();
    test_ignore();
    test_all_sequences();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule